// File: doc/BRIEF.md
# Bias DAC Serial Loader

This block loads an 8-bit bias value into an external serial DAC over a two-wire bus that is emulated in software-style steps. The two bus lines are not real pins: they are two bits of an 8-bit power-control register that sits behind a separate serial register link. Each level change on the bus is therefore sent as one complete register write (a fixed register address plus a full data byte). The remaining six bits of that byte carry a base pattern supplied by the caller, so that the other power controls in the register keep their settings while the bus toggles.

A transfer is launched by a one-cycle start strobe together with the value to load and the base pattern. The block then sends a start condition, a fixed command byte 0x9C, a fixed byte 0x00 and the value byte, each byte followed by an acknowledge slot, and finally a stop condition. The DAC cannot be read back, so each acknowledge slot is clocked with the data line low and nothing is sampled. Every write is offered on a request/ready handshake and held until the link takes it. Busy covers the whole transfer and done marks its end.

Top module: `biasdac_wire_seq`

## Requirements
- R1: While reset is held and right after it is released, the write request, busy and done outputs are low.
- R2: Every write goes to register address 0x03; data bit 0 is the bus clock line, data bit 1 is the bus data line, and bits 7 to 2 equal bits 7 to 2 of the base pattern captured with the start strobe.
- R3: A transfer opens with three writes whose (data, clock) levels are (1,1), then (0,1), then (0,0).
- R4: Each byte bit takes three writes: (b,0), (b,1), (b,0), where b is the bit value; bytes are sent most significant bit first.
- R5: After each byte comes an acknowledge slot sent as a bit with b = 0; the bus is never read.
- R6: The writes follow the order start, byte 0x9C, acknowledge, byte 0x00, acknowledge, value byte, acknowledge, stop: 87 writes in all.
- R7: A transfer closes with three writes whose (data, clock) levels are (0,0), then (0,1), then (1,1).
- R8: The request stays high with address and data unchanged until a cycle in which link ready is high; the write counts as taken in that cycle.
- R9: Busy and the request rise in the cycle after an accepted start strobe; one cycle after the last stop write is taken, busy and the request are low and done is high for exactly one cycle.
- R10: A start strobe while busy is ignored, and changes on the value and base inputs while busy have no effect on the writes of the running transfer.
- R11: Between two consecutive taken writes at most one of the two bus lines changes level.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that launches a transfer when idle |
| value_i | input | 8 | Bias value to load into the DAC |
| base_i | input | 8 | Pattern for the register bits other than the two bus lines |
| link_rdy_i | input | 1 | Serial register link can take a write this cycle |
| wr_req_o | output | 1 | A register write is offered |
| wr_addr_o | output | 8 | Register address of the offered write |
| wr_data_o | output | 8 | Register data of the offered write |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse after the final write is taken |

## Verification
The assertions assume that the link treats a write as taken only in a cycle where both request and ready are high, and that start strobes are single-cycle pulses whose value and base are meaningful only in the launching cycle. The bench keeps to this by driving ready from a seeded random stall rate per transfer, from never stalling to stalling most cycles, and by pulsing start only on an idle block, except in disturbance runs where it deliberately toggles start, value and base while busy and stops toggling start a few writes before the end so that no new transfer can begin in the done cycle.

// File: rtl/biasdac_pkg.sv
package biasdac_pkg;

   // Segment of a transfer currently being emitted.
   typedef enum logic [1:0] {
      SEG_IDLE  = 2'd0,
      SEG_START = 2'd1,
      SEG_BYTE  = 2'd2,
      SEG_STOP  = 2'd3
   } seg_e;

   // Every bus event (start, stop, one bit) is three register writes.
   localparam int unsigned PHASES_PER_SLOT = 3;
   localparam int unsigned PHASE_W         = 2;

   // Levels of the two emulated bus lines for one write.
   typedef struct packed {
      logic dat;
      logic clk;
   } lines_t;

endpackage

// File: rtl/biasdac_step_ctr.sv
module biasdac_step_ctr
   import biasdac_pkg::*;
#(
   parameter int unsigned BITS_PER_BYTE = 8,
   parameter int unsigned N_BYTES       = 3,
   localparam int unsigned BIT_W = $clog2(BITS_PER_BYTE + 1),
   localparam int unsigned SEL_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch_i,
   input  logic               adv_i,
   output seg_e               seg_o,
   output logic [SEL_W-1:0]   byte_sel_o,
   output logic [BIT_W-1:0]   bit_idx_o,
   output logic [PHASE_W-1:0] phase_o,
   output logic               last_o
);

   localparam logic [PHASE_W-1:0] PH_LAST  = PHASE_W'(PHASES_PER_SLOT - 1);
   localparam logic [BIT_W-1:0]   ACK_SLOT = BIT_W'(BITS_PER_BYTE);
   localparam logic [SEL_W-1:0]   SEL_LAST = SEL_W'(N_BYTES - 1);

   if (BITS_PER_BYTE < 1) begin : g_chk_bits
      $error("biasdac_step_ctr: BITS_PER_BYTE must be at least 1");
   end
   if (N_BYTES < 1) begin : g_chk_bytes
      $error("biasdac_step_ctr: N_BYTES must be at least 1");
   end

   seg_e               seg_q;
   logic [SEL_W-1:0]   sel_q;
   logic [BIT_W-1:0]   bit_q;
   logic [PHASE_W-1:0] ph_q;
   logic               slot_end;

   assign slot_end = (ph_q == PH_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q <= SEG_IDLE;
         sel_q <= '0;
         bit_q <= '0;
         ph_q  <= '0;
      end else if (launch_i && seg_q == SEG_IDLE) begin
         seg_q <= SEG_START;
         sel_q <= '0;
         bit_q <= '0;
         ph_q  <= '0;
      end else if (adv_i) begin
         if (!slot_end) begin
            ph_q <= ph_q + PHASE_W'(1);
         end else begin
            ph_q <= '0;
            unique case (seg_q)
               SEG_START: begin
                  seg_q <= SEG_BYTE;
                  sel_q <= '0;
                  bit_q <= '0;
               end
               SEG_BYTE: begin
                  if (bit_q != ACK_SLOT) begin
                     bit_q <= bit_q + BIT_W'(1);
                  end else begin
                     bit_q <= '0;
                     if (sel_q != SEL_LAST) begin
                        sel_q <= sel_q + SEL_W'(1);
                     end else begin
                        seg_q <= SEG_STOP;
                     end
                  end
               end
               SEG_STOP: seg_q <= SEG_IDLE;
               default:  seg_q <= SEG_IDLE;
            endcase
         end
      end
   end

   assign seg_o      = seg_q;
   assign byte_sel_o = sel_q;
   assign bit_idx_o  = bit_q;
   assign phase_o    = ph_q;
   assign last_o     = (seg_q == SEG_STOP) && slot_end;

   // A write can only be taken while a transfer is running.
   AST_NO_ADV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |-> seg_q != SEG_IDLE) else $error("advance while idle"); // R8

   // The opening slot always hands over to the first byte, bit zero.
   AST_START_TO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_q == SEG_START && adv_i && slot_end) |=>
         (seg_q == SEG_BYTE && bit_q == '0 && sel_q == '0)) else $error("bad start exit"); // R6

   // After the stop slot the sequencer is idle again.
   AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && last_o) |=> seg_q == SEG_IDLE) else $error("bad stop exit"); // R9

endmodule

// File: rtl/biasdac_line_gen.sv
module biasdac_line_gen
   import biasdac_pkg::*;
#(
   parameter int unsigned           BITS_PER_BYTE = 8,
   parameter int unsigned           N_BYTES       = 3,
   parameter bit                    MSB_FIRST     = 1'b1,
   parameter logic [BITS_PER_BYTE-1:0] HDR0       = 8'h9C,
   parameter logic [BITS_PER_BYTE-1:0] HDR1       = 8'h00,
   localparam int unsigned BIT_W = $clog2(BITS_PER_BYTE + 1),
   localparam int unsigned SEL_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
   input  seg_e                     seg_i,
   input  logic [SEL_W-1:0]         byte_sel_i,
   input  logic [BIT_W-1:0]         bit_idx_i,
   input  logic [PHASE_W-1:0]       phase_i,
   input  logic [BITS_PER_BYTE-1:0] value_i,
   output lines_t                   lines_o
);

   localparam logic [BIT_W-1:0]   ACK_SLOT = BIT_W'(BITS_PER_BYTE);
   localparam logic [BIT_W-1:0]   TOP_BIT  = BIT_W'(BITS_PER_BYTE - 1);
   localparam logic [PHASE_W-1:0] PH_MID   = PHASE_W'(1);
   localparam logic [PHASE_W-1:0] PH_END   = PHASE_W'(2);

   logic [BITS_PER_BYTE-1:0] cur_byte;
   logic [BITS_PER_BYTE-1:0] shifted;
   logic [BIT_W-1:0]         bit_pos;
   logic                     bit_val;

   // Byte chosen for the current slot: two fixed header bytes, then the value.
   always_comb begin
      if (byte_sel_i == SEL_W'(0))      cur_byte = HDR0;
      else if (byte_sel_i == SEL_W'(1)) cur_byte = HDR1;
      else                              cur_byte = value_i;
   end

   // Shift order is a build-time choice.
   if (MSB_FIRST) begin : g_msb
      assign bit_pos = TOP_BIT - bit_idx_i;
   end else begin : g_lsb
      assign bit_pos = bit_idx_i;
   end

   assign shifted = cur_byte >> bit_pos;
   // The acknowledge slot is clocked with the data line held low.
   assign bit_val = (bit_idx_i == ACK_SLOT) ? 1'b0 : shifted[0];

   always_comb begin
      unique case (seg_i)
         SEG_START: begin
            lines_o.dat = (phase_i == '0);
            lines_o.clk = (phase_i != PH_END);
         end
         SEG_BYTE: begin
            lines_o.dat = bit_val;
            lines_o.clk = (phase_i == PH_MID);
         end
         SEG_STOP: begin
            lines_o.dat = (phase_i == PH_END);
            lines_o.clk = (phase_i != '0);
         end
         default: begin
            lines_o.dat = 1'b1;
            lines_o.clk = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/biasdac_wr_port.sv
module biasdac_wr_port
   import biasdac_pkg::*;
#(
   parameter int unsigned        DATA_W   = 8,
   parameter int unsigned        ADDR_W   = 8,
   parameter logic [ADDR_W-1:0]  REG_ADDR = 8'h03,
   parameter int unsigned        CLK_BIT  = 0,
   parameter int unsigned        DAT_BIT  = 1
) (
   input  logic              active_i,
   input  lines_t            lines_i,
   input  logic [DATA_W-1:0] base_i,
   output logic              req_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);

   if (CLK_BIT == DAT_BIT) begin : g_chk_same
      $error("biasdac_wr_port: clock and data must use distinct bits");
   end
   if (CLK_BIT >= DATA_W || DAT_BIT >= DATA_W) begin : g_chk_range
      $error("biasdac_wr_port: bus line bit outside the data word");
   end

   // Each bit of the word is either a bus line or a copy of the base pattern.
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == CLK_BIT) begin : g_clk
         assign data_o[i] = lines_i.clk;
      end else if (i == DAT_BIT) begin : g_dat
         assign data_o[i] = lines_i.dat;
      end else begin : g_base
         assign data_o[i] = base_i[i];
      end
   end

   assign req_o  = active_i;
   assign addr_o = REG_ADDR;

endmodule

// File: rtl/biasdac_wire_seq.sv
module biasdac_wire_seq
   import biasdac_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned VAL_W      = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 8'h03,
   parameter int unsigned CLK_BIT    = 0,
   parameter int unsigned DAT_BIT    = 1,
   parameter logic [VAL_W-1:0] HDR0  = 8'h9C,
   parameter logic [VAL_W-1:0] HDR1  = 8'h00,
   parameter bit          MSB_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [VAL_W-1:0]  value_i,
   input  logic [DATA_W-1:0] base_i,
   input  logic              link_rdy_i,
   output logic              wr_req_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int unsigned N_BYTES = 3;
   localparam int unsigned BIT_W   = $clog2(VAL_W + 1);
   localparam int unsigned SEL_W   = $clog2(N_BYTES);

   if (DATA_W < 2) begin : g_chk_width
      $error("biasdac_wire_seq: register word must hold both bus lines");
   end

   seg_e               seg;
   logic [SEL_W-1:0]   byte_sel;
   logic [BIT_W-1:0]   bit_idx;
   logic [PHASE_W-1:0] phase;
   logic               last_step;
   logic               launch;
   logic               adv;
   logic [VAL_W-1:0]   value_q;
   logic [DATA_W-1:0]  base_q;
   logic               done_q;
   lines_t             lines;

   assign busy_o = (seg != SEG_IDLE);
   assign launch = start_i && !busy_o;
   assign adv    = wr_req_o && link_rdy_i;

   // Operands are frozen for the whole transfer.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q <= '0;
         base_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         if (launch) begin
            value_q <= value_i;
            base_q  <= base_i;
         end
         done_q <= adv && last_step;
      end
   end

   assign done_o = done_q;

   biasdac_step_ctr #(
      .BITS_PER_BYTE (VAL_W),
      .N_BYTES       (N_BYTES)
   ) u_steps (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch_i   (launch),
      .adv_i      (adv),
      .seg_o      (seg),
      .byte_sel_o (byte_sel),
      .bit_idx_o  (bit_idx),
      .phase_o    (phase),
      .last_o     (last_step)
   );

   biasdac_line_gen #(
      .BITS_PER_BYTE (VAL_W),
      .N_BYTES       (N_BYTES),
      .MSB_FIRST     (MSB_FIRST),
      .HDR0          (HDR0),
      .HDR1          (HDR1)
   ) u_lines (
      .seg_i      (seg),
      .byte_sel_i (byte_sel),
      .bit_idx_i  (bit_idx),
      .phase_i    (phase),
      .value_i    (value_q),
      .lines_o    (lines)
   );

   biasdac_wr_port #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .REG_ADDR (REG_ADDR),
      .CLK_BIT  (CLK_BIT),
      .DAT_BIT  (DAT_BIT)
   ) u_port (
      .active_i (busy_o),
      .lines_i  (lines),
      .base_i   (base_q),
      .req_o    (wr_req_o),
      .addr_o   (wr_addr_o),
      .data_o   (wr_data_o)
   );

   // Last taken bus levels, kept only for the line-change check.
   logic [1:0] prev_lines;
   logic       prev_vld;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lines <= 2'b11;
         prev_vld   <= 1'b0;
      end else if (adv) begin
         prev_lines <= {wr_data_o[DAT_BIT], wr_data_o[CLK_BIT]};
         prev_vld   <= 1'b1;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && !link_rdy_i) |=>
         (wr_req_o && $stable(wr_data_o) && $stable(wr_addr_o))) else $error("write dropped"); // R8

   AST_BASE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && $past(wr_req_o)) |->
         ((wr_data_o ^ $past(wr_data_o)) & ~((DATA_W'(1) << CLK_BIT) | (DATA_W'(1) << DAT_BIT))) == '0)
      else $error("base bits moved"); // R2

   AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (wr_data_o[CLK_BIT] && wr_data_o[DAT_BIT])) else $error("bad first write"); // R3

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o) else $error("done too long"); // R9

   AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !wr_req_o && $past(busy_o))) else $error("done while busy"); // R9

   AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && prev_vld) |->
         $countones(prev_lines ^ {wr_data_o[DAT_BIT], wr_data_o[CLK_BIT]}) <= 1)
      else $error("two lines moved"); // R11

endmodule

// File: tb/tb_biasdac_wire_seq.sv
module tb_biasdac_wire_seq;

   localparam int CLK_PERIOD = 10;
   localparam int NSTEPS     = 87;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] value_i = '0;
   logic [7:0] base_i = '0;
   logic       link_rdy_i = 1'b0;
   logic       wr_req_o;
   logic [7:0] wr_addr_o;
   logic [7:0] wr_data_o;
   logic       busy_o;
   logic       done_o;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   biasdac_wire_seq dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .value_i    (value_i),
      .base_i     (base_i),
      .link_rdy_i (link_rdy_i),
      .wr_req_o   (wr_req_o),
      .wr_addr_o  (wr_addr_o),
      .wr_data_o  (wr_data_o),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

   // Expected {data, clock} levels of write number idx.
   function automatic logic [1:0] exp_lines(int idx, logic [7:0] v);
      logic [7:0] by;
      int k, r, bp, sub;
      logic b;
      if (idx < 3) return (idx == 0) ? 2'b11 : (idx == 1) ? 2'b01 : 2'b00;
      if (idx >= 84) return (idx == 84) ? 2'b00 : (idx == 85) ? 2'b01 : 2'b11;
      k   = idx - 3;
      by  = (k / 27 == 0) ? 8'h9C : (k / 27 == 1) ? 8'h00 : v;
      r   = k % 27;
      bp  = r / 3;
      sub = r % 3;
      b   = (bp == 8) ? 1'b0 : by[7 - bp];
      return {b, (sub == 1)};
   endfunction

   function automatic logic [7:0] exp_word(int idx, logic [7:0] b, logic [7:0] v);
      return {b[7:2], exp_lines(idx, v)};
   endfunction

   function automatic string tag_of(int idx);
      if (idx < 3)   return "R3";
      if (idx >= 84) return "R7";
      if (((idx - 3) % 27) / 3 == 8) return "R5";
      return "R4";
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_xfer(input logic [7:0] v, input logic [7:0] b, input int stall_pct, input bit disturb);
      int idx = 0;
      int cyc = 0;
      bit stalled = 0;
      logic [1:0] prev_acc = 2'b11;
      logic [7:0] ew;
      @(negedge clk);
      start_i = 1'b1; value_i = v; base_i = b;
      @(negedge clk);
      start_i = 1'b0;
      while (idx < NSTEPS && cyc < 5000) begin
         ew = exp_word(idx, b, v);
         chk(wr_req_o === 1'b1 && busy_o === 1'b1, "R9", {6'd0, busy_o, wr_req_o}, 8'h03);
         chk(wr_addr_o === 8'h03, "R2", wr_addr_o, 8'h03);
         chk(wr_data_o === ew, stalled ? "R8" : (disturb ? "R10" : tag_of(idx)), wr_data_o, ew);
         chk(wr_data_o[7:2] === b[7:2], "R2", {2'b0, wr_data_o[7:2]}, {2'b0, b[7:2]});
         link_rdy_i = ($urandom_range(99) >= stall_pct);
         if (disturb) begin
            start_i = (idx < 80) ? 1'($urandom_range(1)) : 1'b0;
            value_i = 8'($urandom);
            base_i  = 8'($urandom);
         end
         if (link_rdy_i) begin
            if (idx > 0)
               chk(($countones(prev_acc ^ wr_data_o[1:0]) <= 1), "R11",
                   {6'd0, wr_data_o[1:0]}, {6'd0, prev_acc});
            prev_acc = wr_data_o[1:0];
            idx++;
            stalled = 0;
         end else begin
            stalled = 1;
         end
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0;
      chk(idx == NSTEPS, "R6", 8'(idx), 8'(NSTEPS));
      chk(done_o === 1'b1 && busy_o === 1'b0 && wr_req_o === 1'b0, "R9",
          {5'd0, done_o, busy_o, wr_req_o}, 8'h04);
      link_rdy_i = 1'($urandom_range(1));
      @(negedge clk);
      chk(done_o === 1'b0 && wr_req_o === 1'b0 && busy_o === 1'b0,
          disturb ? "R10" : "R9", {5'd0, done_o, busy_o, wr_req_o}, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      chk(wr_req_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R1",
          {5'd0, done_o, busy_o, wr_req_o}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wr_req_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R1",
          {5'd0, done_o, busy_o, wr_req_o}, 8'h00);

      // Directed corners: no stall, heavy stall, extreme values and bases.
      run_xfer(8'h7D, 8'hFC, 0, 1'b0);
      run_xfer(8'h00, 8'h00, 85, 1'b0);
      run_xfer(8'hFF, 8'hA8, 40, 1'b0);
      run_xfer(8'hA5, 8'h54, 20, 1'b1);
      for (int t = 0; t < 10; t++) begin
         run_xfer(8'($urandom), 8'($urandom), int'($urandom_range(70)), 1'($urandom_range(1)));
         repeat (int'($urandom_range(3))) @(negedge clk);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule